// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor

This block is a 32-bit processor core that fetches, decodes and retires one instruction in every clock cycle. It recognises seven operations: register add, register subtract, OR with an unsigned immediate, word load, word store, branch when two registers are equal, and an unconditional jump. Inside it sit a 32-entry register file, an immediate extender, a three-operation ALU that reports a zero result, a next-PC unit and a hardwired decoder. The decoder turns the opcode and function fields into the datapath controls: which field names the destination, whether the ALU takes a register or the immediate as its second operand, and whether the immediate is sign- or zero-extended.

Program and data live in two small word arrays inside the core. A load port fills them while the core is held in reset. The core then runs from address 0. For every instruction the ports show the PC, the fetched word and the write that will commit on the coming rising edge, for the register file and for data memory.

Top module: `mini_core`

## Requirements
- R1: With opcode 000000, funct 100000 writes R[rd] = R[rs] + R[rt] and funct 100010 writes R[rd] = R[rs] - R[rt]; the PC advances by 4.
- R2: Opcode 001101 writes R[rt] = R[rs] OR the 16-bit immediate in bits 15:0, zero-extended.
- R3: Opcode 100011 reads the data word at byte address R[rs] + sign-extended immediate and writes it to R[rt].
- R4: Opcode 101011 writes R[rt] to data memory at byte address R[rs] + sign-extended immediate and does not write the register file. A following load from that address returns the stored word.
- R5: Opcode 000100 writes nothing. When R[rs] equals R[rt] the next PC is PC + 4 + (sign-extended immediate << 2), and a negative offset works. Otherwise the next PC is PC + 4.
- R6: Opcode 000010 writes nothing. The next PC is {(PC+4)[31:28], bits 25:0 of the instruction, 2'b00}.
- R7: Register 0 always reads as zero. A write aimed at it is dropped, and reg_we_o stays low for it.
- R8: Any other opcode, and an opcode-000000 word with any other funct, writes nothing and advances the PC by 4.
- R9: rst_n is active-low and sampled on the rising edge. The first edge with rst_n low sets the PC to 0, and no register or memory write is reported or made while rst_n is low.
- R10: When ld_en is high, the rising edge writes ld_data into word ld_word of instruction memory (ld_sel = 0) or of data memory (ld_sel = 1). Instructions are fetched from word PC[7:2] and data from word address[7:2] with the default depth of 64 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_word | input | 6 | Word index written by the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Address of the instruction now executing |
| instr_o | output | 32 | Instruction word now executing |
| reg_we_o | output | 1 | Register write commits on the next edge |
| reg_waddr_o | output | 5 | Destination register of that write |
| reg_wdata_o | output | 32 | Value of that write |
| mem_we_o | output | 1 | Data-memory write commits on the next edge |
| mem_addr_o | output | 32 | Byte address computed by the ALU |
| mem_wdata_o | output | 32 | Store data, R[rt] |

## Verification
Every stage is combinational except the PC and the two storage arrays. A wrong decode therefore shows on reg_we_o, reg_waddr_o, reg_wdata_o or mem_we_o in the same cycle as the faulty instruction, and a wrong next-PC choice shows on pc_o one edge later. A register or memory word that was written wrongly stays hidden until a later instruction reads it. For that reason the program reads back its own results: add after ori, load after store, and add from register 0. A bad write then surfaces at the write ports within a few instructions. Branch and jump targets are compared against the trace of pc_o, so a taken path that should not be taken, or the reverse, changes every later step.

// File: rtl/cpu_pkg.sv
// Shared encodings and control bundle for the single-cycle core.
// Assumes 32-bit instruction words with the fixed field layout below.
package cpu_pkg;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JMP   = 6'b000010;

    localparam logic [5:0] FN_ADD   = 6'b100000;
    localparam logic [5:0] FN_SUB   = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    reg_wr;      // write the register file
        logic    dst_rd;      // destination from rd (else rt)
        logic    b_is_imm;    // ALU operand B from the extender
        logic    imm_signed;  // sign-extend (else zero-extend)
        logic    load_sel;    // write-back from data memory
        logic    mem_wr;      // write data memory
        logic    is_branch;   // conditional branch on zero
        logic    is_jump;     // absolute jump
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/cpu_decoder.sv
// Main decoder: maps opcode and funct to datapath controls.
// Assumes: unknown encodings must produce an all-quiet bundle (a no-op).
module cpu_decoder
    import cpu_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Decode one instruction into controls; defaults form a no-op.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (op)
            OP_RTYPE: begin
                if (funct == FN_ADD) begin
                    ctrl.reg_wr = 1'b1;
                    ctrl.dst_rd = 1'b1;
                    ctrl.alu_op = ALU_ADD;
                end else if (funct == FN_SUB) begin
                    ctrl.reg_wr = 1'b1;
                    ctrl.dst_rd = 1'b1;
                    ctrl.alu_op = ALU_SUB;
                end
            end
            OP_ORI: begin
                ctrl.reg_wr   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            OP_LW: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.b_is_imm   = 1'b1;
                ctrl.imm_signed = 1'b1;
                ctrl.load_sel   = 1'b1;
            end
            OP_SW: begin
                ctrl.mem_wr     = 1'b1;
                ctrl.b_is_imm   = 1'b1;
                ctrl.imm_signed = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OP_JMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/cpu_regfile.sv
// Register file: two asynchronous read ports, one write port on the rising edge.
// Assumes: entry 0 is constant zero; no reset of contents.
module cpu_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);

    logic [XLEN-1:0] regs [NREGS];

    // Commit a write; entry 0 is never stored.
    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Read port A, with entry 0 forced to zero.
    always_comb rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];

    // Read port B, with entry 0 forced to zero.
    always_comb rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/cpu_alu.sv
// Three-operation ALU with a zero-result flag.
// Assumes: the decoder only issues ADD, SUB or OR.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] result,
    output logic            zero
);

    // Select the operation result.
    always_comb begin
        case (op)
            ALU_SUB: result = a - b;
            ALU_OR:  result = a | b;
            default: result = a + b;
        endcase
    end

    // Flag an all-zero result for branch compare.
    always_comb zero = (result == '0);

endmodule

// File: rtl/cpu_next_pc.sv
// Next-PC unit: sequential, taken-branch or jump target.
// Assumes: XLEN is 32 so the jump keeps PC+4 bits 31:28.
module cpu_next_pc #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm_sext,
    input  logic [25:0]     jump_field,
    input  logic            is_branch,
    input  logic            is_jump,
    input  logic            alu_zero,
    output logic [XLEN-1:0] pc_next
);

    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;

    // Candidate targets.
    always_comb begin
        pc_plus4   = pc + XLEN'(4);
        br_target  = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
        jmp_target = {pc_plus4[XLEN-1:28], jump_field, 2'b00};
    end

    // Pick the target; jump wins, branch needs the zero flag.
    always_comb begin
        if (is_jump)                     pc_next = jmp_target;
        else if (is_branch && alu_zero)  pc_next = br_target;
        else                             pc_next = pc_plus4;
    end

endmodule

// File: rtl/mini_core.sv
// Single-cycle core top: PC, fetch, decode, execute, memory and write-back.
// Assumes: memories are word arrays of MEM_WORDS entries, filled through the
// load port while rst_n is low; sub-word access does not exist.
module mini_core
    import cpu_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NREGS     = 32,
    parameter int MEM_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_en,
    input  logic                         ld_sel,
    input  logic [$clog2(MEM_WORDS)-1:0] ld_word,
    input  logic [XLEN-1:0]              ld_data,
    output logic [XLEN-1:0]              pc_o,
    output logic [31:0]                  instr_o,
    output logic                         reg_we_o,
    output logic [$clog2(NREGS)-1:0]     reg_waddr_o,
    output logic [XLEN-1:0]              reg_wdata_o,
    output logic                         mem_we_o,
    output logic [XLEN-1:0]              mem_addr_o,
    output logic [XLEN-1:0]              mem_wdata_o
);

    localparam int MAW = $clog2(MEM_WORDS);
    localparam int RAW = $clog2(NREGS);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [31:0]     instr;
    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];
    ctrl_t           ctrl;

    logic [RAW-1:0]  rs_f, rt_f, rd_f, dst;
    logic [15:0]     imm16;
    logic [XLEN-1:0] imm_sext, imm_zext, imm_ext;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_res, load_word, wb_val;
    logic            alu_zero;
    logic            rf_we, dm_we;
    logic            unused_bits;

    // Program counter; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Instruction memory: load-port writes only.
    always_ff @(posedge clk) begin
        if (ld_en && !ld_sel) imem[ld_word] <= ld_data;
    end

    // Fetch and field split.
    always_comb begin
        instr = imem[pc_q[MAW+1:2]];
        rs_f  = instr[25:21];
        rt_f  = instr[20:16];
        rd_f  = instr[15:11];
        imm16 = instr[15:0];
    end

    cpu_decoder i_dec (
        .op    (instr[31:26]),
        .funct (instr[5:0]),
        .ctrl  (ctrl)
    );

    cpu_regfile #(.XLEN(XLEN), .NREGS(NREGS)) i_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (dst),
        .wdata   (wb_val),
        .raddr_a (rs_f),
        .raddr_b (rt_f),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    // Immediate extension and ALU operand B selection.
    always_comb begin
        imm_sext = {{(XLEN-16){imm16[15]}}, imm16};
        imm_zext = {{(XLEN-16){1'b0}}, imm16};
        imm_ext  = ctrl.imm_signed ? imm_sext : imm_zext;
        alu_b    = ctrl.b_is_imm ? imm_ext : rt_val;
    end

    cpu_alu #(.XLEN(XLEN)) i_alu (
        .op     (ctrl.alu_op),
        .a      (rs_val),
        .b      (alu_b),
        .result (alu_res),
        .zero   (alu_zero)
    );

    cpu_next_pc #(.XLEN(XLEN)) i_npc (
        .pc         (pc_q),
        .imm_sext   (imm_sext),
        .jump_field (instr[25:0]),
        .is_branch  (ctrl.is_branch),
        .is_jump    (ctrl.is_jump),
        .alu_zero   (alu_zero),
        .pc_next    (pc_next)
    );

    // Data memory: load port has priority over a store.
    always_ff @(posedge clk) begin
        if (ld_en && ld_sel) dmem[ld_word] <= ld_data;
        else if (dm_we)      dmem[alu_res[MAW+1:2]] <= rt_val;
    end

    // Write-back value, destination and gated write enables.
    always_comb begin
        load_word = dmem[alu_res[MAW+1:2]];
        wb_val    = ctrl.load_sel ? load_word : alu_res;
        dst       = ctrl.dst_rd ? rd_f : rt_f;
        rf_we     = ctrl.reg_wr && rst_n && (dst != '0);
        dm_we     = ctrl.mem_wr && rst_n;
    end

    // Observation ports.
    always_comb begin
        pc_o        = pc_q;
        instr_o     = instr;
        reg_we_o    = rf_we;
        reg_waddr_o = dst;
        reg_wdata_o = wb_val;
        mem_we_o    = dm_we;
        mem_addr_o  = alu_res;
        mem_wdata_o = rt_val;
        unused_bits = ^{pc_q[1:0], alu_zero};
    end

endmodule

// File: rtl/mini_core_chk.sv
// Property checker for mini_core, attached by bind below.
// Assumes: only top-level ports are observed.
module mini_core_chk
    import cpu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [XLEN-1:0]          pc_o,
    input logic [31:0]              instr_o,
    input logic                     reg_we_o,
    input logic [$clog2(NREGS)-1:0] reg_waddr_o,
    input logic                     mem_we_o
);

    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] jmp_pc;

    // Branch offset and jump target rebuilt from the instruction port.
    always_comb begin
        br_off = {{(XLEN-18){instr_o[15]}}, instr_o[15:0], 2'b00};
        jmp_pc = {pc_o[XLEN-1:28] + ((pc_o[27:0] >= 28'hFFFFFFC) ? 4'd1 : 4'd0),
                  instr_o[25:0], 2'b00};
    end

    AST_RESET_PC: assert property (@(posedge clk)
        !rst_n |=> pc_o == '0);  // R9

    AST_NO_WR_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> !reg_we_o && !mem_we_o);  // R9

    AST_R0_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> reg_waddr_o != '0);  // R7

    AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (!rst_n)
        instr_o[31:26] == OP_SW |-> mem_we_o && !reg_we_o);  // R4

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_o[31:26] != OP_BEQ && instr_o[31:26] != OP_JMP)
        |=> pc_o == $past(pc_o) + XLEN'(4));  // R8

    AST_BEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        instr_o[31:26] == OP_BEQ
        |=> (pc_o == $past(pc_o) + XLEN'(4))
         || (pc_o == $past(pc_o) + XLEN'(4) + $past(br_off)));  // R5

    AST_JUMP_PC: assert property (@(posedge clk) disable iff (!rst_n)
        instr_o[31:26] == OP_JMP |=> pc_o == $past(jmp_pc));  // R6

    AST_BRJ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_o[31:26] == OP_BEQ || instr_o[31:26] == OP_JMP)
        |-> !reg_we_o && !mem_we_o);  // R5

endmodule

bind mini_core mini_core_chk #(.XLEN(XLEN), .NREGS(NREGS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_o        (pc_o),
    .instr_o     (instr_o),
    .reg_we_o    (reg_we_o),
    .reg_waddr_o (reg_waddr_o),
    .mem_we_o    (mem_we_o)
);

// File: tb/test_mini_core.sv
module test_mini_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [5:0]  ld_word = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, instr_o, reg_wdata_o, mem_addr_o, mem_wdata_o;
    logic        reg_we_o, mem_we_o;
    logic [4:0]  reg_waddr_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mini_core i_mini_core (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_word(ld_word), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
        .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o), .reg_wdata_o(reg_wdata_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                          logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    localparam int PN = 21;
    localparam logic [31:0] PROG [PN] = '{
        enc_i(6'h0D, 5'd0, 5'd1, 16'h0005),   // 0  ori r1=5           R2
        enc_i(6'h0D, 5'd0, 5'd2, 16'hFFFF),   // 4  ori r2=0000FFFF    R2
        enc_r(5'd1, 5'd2, 5'd3, 6'h20),       // 8  add r3             R1
        enc_r(5'd1, 5'd2, 5'd4, 6'h22),       // 12 sub r4             R1
        enc_i(6'h23, 5'd0, 5'd5, 16'h0008),   // 16 lw r5,8(r0)        R3
        enc_i(6'h0D, 5'd0, 5'd7, 16'h0010),   // 20 ori r7=16
        enc_i(6'h23, 5'd7, 5'd6, 16'hFFFC),   // 24 lw r6,-4(r7)       R3
        enc_i(6'h2B, 5'd7, 5'd4, 16'h0004),   // 28 sw r4,4(r7)        R4
        enc_i(6'h23, 5'd0, 5'd8, 16'h0014),   // 32 lw r8,20(r0)       R4
        enc_r(5'd1, 5'd1, 5'd0, 6'h20),       // 36 add r0 (dropped)   R7
        enc_r(5'd0, 5'd1, 5'd9, 6'h20),       // 40 add r9=r0+r1       R7
        enc_i(6'h04, 5'd1, 5'd9, 16'h0002),   // 44 beq taken -> 56    R5
        enc_i(6'h0D, 5'd0, 5'd10, 16'h0001),  // 48 skipped
        enc_i(6'h0D, 5'd0, 5'd10, 16'h0002),  // 52 skipped
        enc_i(6'h04, 5'd1, 5'd2, 16'h0005),   // 56 beq not taken      R5
        32'hFC00_0000,                        // 60 unknown opcode     R8
        enc_r(5'd1, 5'd2, 5'd11, 6'h25),      // 64 unknown funct      R8
        enc_j(26'd20),                        // 68 j -> 80            R6
        enc_i(6'h0D, 5'd0, 5'd10, 16'h0003),  // 72 skipped
        enc_i(6'h0D, 5'd0, 5'd10, 16'h0004),  // 76 skipped
        enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF)    // 80 beq self loop      R5
    };

    typedef struct packed {
        logic [31:0] pc;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        mwe;
        logic [31:0] ma;
        logic [31:0] md;
    } step_t;

    localparam int TN = 18;
    localparam step_t TRACE [TN] = '{
        '{32'd0,  1'b1, 5'd1, 32'h0000_0005, 1'b0, 32'd0,  32'd0},
        '{32'd4,  1'b1, 5'd2, 32'h0000_FFFF, 1'b0, 32'd0,  32'd0},
        '{32'd8,  1'b1, 5'd3, 32'h0001_0004, 1'b0, 32'd0,  32'd0},
        '{32'd12, 1'b1, 5'd4, 32'hFFFF_0006, 1'b0, 32'd0,  32'd0},
        '{32'd16, 1'b1, 5'd5, 32'hCAFE_F00D, 1'b0, 32'd0,  32'd0},
        '{32'd20, 1'b1, 5'd7, 32'h0000_0010, 1'b0, 32'd0,  32'd0},
        '{32'd24, 1'b1, 5'd6, 32'h1234_5678, 1'b0, 32'd0,  32'd0},
        '{32'd28, 1'b0, 5'd0, 32'd0,         1'b1, 32'd20, 32'hFFFF_0006},
        '{32'd32, 1'b1, 5'd8, 32'hFFFF_0006, 1'b0, 32'd0,  32'd0},
        '{32'd36, 1'b0, 5'd0, 32'd0,         1'b0, 32'd0,  32'd0},
        '{32'd40, 1'b1, 5'd9, 32'h0000_0005, 1'b0, 32'd0,  32'd0},
        '{32'd44, 1'b0, 5'd0, 32'd0,         1'b0, 32'd0,  32'd0},
        '{32'd56, 1'b0, 5'd0, 32'd0,         1'b0, 32'd0,  32'd0},
        '{32'd60, 1'b0, 5'd0, 32'd0,         1'b0, 32'd0,  32'd0},
        '{32'd64, 1'b0, 5'd0, 32'd0,         1'b0, 32'd0,  32'd0},
        '{32'd68, 1'b0, 5'd0, 32'd0,         1'b0, 32'd0,  32'd0},
        '{32'd80, 1'b0, 5'd0, 32'd0,         1'b0, 32'd0,  32'd0},
        '{32'd80, 1'b0, 5'd0, 32'd0,         1'b0, 32'd0,  32'd0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic load_word(logic sel, logic [5:0] idx, logic [31:0] val);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_sel  = sel;
        ld_word = idx;
        ld_data = val;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    // Tag of the requirement each trace step exercises.
    function automatic string step_req(int k);
        case (k)
            0, 1, 5: return "R2";
            2, 3:    return "R1";
            4, 6:    return "R3";
            7, 8:    return "R4";
            9, 10:   return "R7";
            11, 12, 16, 17: return "R5";
            13, 14:  return "R8";
            default: return "R6";
        endcase
    endfunction

    initial begin
        // Preload while held in reset (R10).
        for (int i = 0; i < PN; i++) load_word(1'b0, 6'(i), PROG[i]);
        load_word(1'b1, 6'd2, 32'hCAFE_F00D);
        load_word(1'b1, 6'd3, 32'h1234_5678);
        @(negedge clk);
        #1;
        check("R9 pc in reset", pc_o, 32'd0);
        check("R9 no reg write in reset", {31'd0, reg_we_o}, 32'd0);
        check("R9 no mem write in reset", {31'd0, mem_we_o}, 32'd0);
        check("R10 fetched word", instr_o, PROG[0]);

        rst_n = 1'b1;
        for (int k = 0; k < TN; k++) begin
            if (k != 0) @(negedge clk);
            #1;
            check({step_req(k), " pc"}, pc_o, TRACE[k].pc);
            check({step_req(k), " reg_we"}, {31'd0, reg_we_o}, {31'd0, TRACE[k].we});
            check({step_req(k), " mem_we"}, {31'd0, mem_we_o}, {31'd0, TRACE[k].mwe});
            if (TRACE[k].we) begin
                check({step_req(k), " waddr"}, {27'd0, reg_waddr_o}, {27'd0, TRACE[k].wa});
                check({step_req(k), " wdata"}, reg_wdata_o, TRACE[k].wd);
            end
            if (TRACE[k].mwe) begin
                check({step_req(k), " mem addr"}, mem_addr_o, TRACE[k].ma);
                check({step_req(k), " mem data"}, mem_wdata_o, TRACE[k].md);
            end
        end

        // Reset is synchronous: no PC change before the edge (R9).
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 pc held before edge", pc_o, 32'd80);
        check("R9 writes gated", {30'd0, reg_we_o, mem_we_o}, 32'd0);
        @(negedge clk);
        #1;
        check("R9 pc cleared at edge", pc_o, 32'd0);

        // Restart: register file kept r1 and data memory kept the store (R4).
        rst_n = 1'b1;
        #1;
        check("R2 restart ori", reg_wdata_o, 32'd5);
        repeat (8) @(negedge clk);
        #1;
        check("R4 reload of stored word", reg_wdata_o, 32'hFFFF_0006);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule